// File: doc/BRIEF.md
# Bus Parity Error Reporter

This block sits beside a PCI-style bus agent and checks the even parity of every bus phase the agent is entitled to check. Address and command bits are captured in the cycle they appear. The parity bit arrives one clock later and is compared against them. The block then raises one of two error reports.

The data-error report is a sustained tri-state line. It goes low two clocks after a bad data phase and stays low for one clock per bad phase. It is then driven high for one clock before the driver lets go. The system-error report is open drain: one low clock, never driven high. Each report has its own enable. Two sticky flags record a detected parity error and a signalled system error, and each is cleared by a write-one-to-clear strobe.

The agent supplies its bus role:
- `claimed_i` says the agent has asserted device select as target.
- `master_i` says the agent owns the current transaction.

From these and the latched command, the block works out on its own which data phases the agent receives.

Top module: `pci_parity_reporter`

## Requirements
- R1: For a completed, received data phase whose AD and C/BE# bits plus the PAR value on the next clock have odd total parity, with `perr_en_i` set, `perr_oe_o` is high and `perr_o` is low exactly two clocks after the data phase.
- R2: Each erroneous data phase produces exactly one low clock on `perr_o`, so consecutive erroneous phases give an unbroken low stretch of the same length.
- R3: After its last low clock, `perr_o` is driven high with `perr_oe_o` set for exactly one clock, then `perr_oe_o` drops. `perr_oe_o` is never set at any other time.
- R4: A data phase is checked only when it completes, with `irdy_n_i` and `trdy_n_i` both low. As target, the agent checks it only when `claimed_i` is high and the command bit 0 is 1 (a write). As master (`master_i` high), the agent checks it only when command bit 0 is 0 (a read). Bad parity in a wait state or in a phase the agent does not receive is ignored.
- R5: An address phase (the first clock with `frame_n_i` low after a clock with it high, command on `cbe_n_i[3:0]`) with bad parity, seen while `master_i` is low, sets `serr_oe_o` for exactly one clock, two clocks later. `serr_o` is always 0.
- R6: After a command of 4'b0001 (broadcast cycle), a data phase with `irdy_n_i` low and bad parity is reported on the system-error output, never on `perr_o`. This applies when `master_i` is low.
- R7: With `perr_en_i` low, a data parity error leaves `perr_oe_o` low. With `serr_en_i` low, an address or broadcast parity error leaves `serr_oe_o` and `sse_o` low.
- R8: `dpe_o` is set in the cycle a report of any checked parity error would appear, whatever the enables. `sse_o` is set with each system-error pulse. `clr_dpe_i` and `clr_sse_i` clear their flag on the next clock, and a new event in that same clock wins over the clear.
- R9: A synchronous high `rst` releases both outputs, clears the sticky flags and discards any error already in the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 32 | Address/data bus |
| cbe_n_i | input | 4 | Command / byte enables, active low |
| par_i | input | 1 | Even parity over the previous clock's AD and C/BE# |
| frame_n_i | input | 1 | Transaction frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| claimed_i | input | 1 | Agent has claimed the access as target |
| master_i | input | 1 | Agent is master of the current transaction |
| perr_en_i | input | 1 | Enable for the data-error report |
| serr_en_i | input | 1 | Enable for the system-error report |
| clr_dpe_i | input | 1 | Write-one-to-clear for `dpe_o` |
| clr_sse_i | input | 1 | Write-one-to-clear for `sse_o` |
| perr_o | output | 1 | Data-error drive value |
| perr_oe_o | output | 1 | Data-error output enable |
| serr_o | output | 1 | System-error drive value (always 0) |
| serr_oe_o | output | 1 | System-error output enable |
| dpe_o | output | 1 | Sticky detected-parity-error flag |
| sse_o | output | 1 | Sticky signalled-system-error flag |

## Verification
The sticky parity flag can be set by a newly detected error and cleared by its strobe on the same clock edge. The bench provokes this by asserting `clr_dpe_i` in the clock that carries PAR for a bad data phase, so that the detection and the clear land on one register update. The flag must read 1 afterwards. A further clear on a quiet cycle must bring it to 0. A second collision places a bad final data phase directly before a bad address phase. The bench judges that the data-error low clock and the system-error pulse appear on consecutive cycles, with neither disturbing the other.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SPEC = 2'd3
  } phase_e;

  localparam logic [3:0] CMD_BCAST = 4'b0001;
endpackage

// File: rtl/ppr_phase_decode.sv
module ppr_phase_decode
  import ppr_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            frame_n_i,
  input  logic            irdy_n_i,
  input  logic            trdy_n_i,
  input  logic            claimed_i,
  input  logic            master_i,
  output phase_e          phase_q,
  output logic [AD_W-1:0] ad_q,
  output logic [BE_W-1:0] cbe_q
);
  logic       frame_d;
  logic [3:0] cmd_q;
  logic       addr_ph;
  logic       bcast;
  logic       rx;
  phase_e     phase_d;

  always_comb begin
    addr_ph = !frame_n_i && frame_d;
    bcast   = (cmd_q == CMD_BCAST);
    // target receives on writes (bit0 = 1), master receives on reads
    rx      = master_i ? !cmd_q[0] : (cmd_q[0] && claimed_i);
    if (addr_ph)
      phase_d = master_i ? PH_IDLE : PH_ADDR;
    else if (bcast && !irdy_n_i && !master_i)
      phase_d = PH_SPEC;
    else if (!bcast && !irdy_n_i && !trdy_n_i && rx)
      phase_d = PH_DATA;
    else
      phase_d = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_d <= 1'b1;
      cmd_q   <= 4'hF;
      phase_q <= PH_IDLE;
      ad_q    <= '0;
      cbe_q   <= '0;
    end else begin
      frame_d <= frame_n_i;
      if (addr_ph) cmd_q <= cbe_n_i[3:0];
      phase_q <= phase_d;
      ad_q    <= ad_i;
      cbe_q   <= cbe_n_i;
    end
  end
endmodule

// File: rtl/ppr_parity_check.sv
module ppr_parity_check
  import ppr_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = AD_W / 8
) (
  input  phase_e          phase_q,
  input  logic [AD_W-1:0] ad_q,
  input  logic [BE_W-1:0] cbe_q,
  input  logic            par_i,
  output logic            data_err,
  output logic            addr_err,
  output logic            spec_err
);
  logic [BE_W-1:0] lane_p;
  logic            mismatch;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_p[g] = (^ad_q[g*8 +: 8]) ^ cbe_q[g];
  end

  always_comb begin
    mismatch = (^lane_p) ^ par_i;
    data_err = mismatch && (phase_q == PH_DATA);
    addr_err = mismatch && (phase_q == PH_ADDR);
    spec_err = mismatch && (phase_q == PH_SPEC);
  end
endmodule

// File: rtl/ppr_report.sv
module ppr_report (
  input  logic clk,
  input  logic rst,
  input  logic data_err,
  input  logic addr_err,
  input  logic spec_err,
  input  logic perr_en_i,
  input  logic serr_en_i,
  input  logic clr_dpe_i,
  input  logic clr_sse_i,
  output logic perr_o,
  output logic perr_oe_o,
  output logic serr_o,
  output logic serr_oe_o,
  output logic dpe_o,
  output logic sse_o
);
  logic perr_fire;
  logic serr_fire;
  logic any_err;

  always_comb begin
    perr_fire = data_err && perr_en_i;
    serr_fire = (addr_err || spec_err) && serr_en_i;
    any_err   = data_err || addr_err || spec_err;
  end

  assign serr_o = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_o    <= 1'b1;
      perr_oe_o <= 1'b0;
      serr_oe_o <= 1'b0;
      dpe_o     <= 1'b0;
      sse_o     <= 1'b0;
    end else begin
      perr_o    <= !perr_fire;
      // stay enabled one clock past the last low clock to drive high
      perr_oe_o <= perr_fire || !perr_o;
      serr_oe_o <= serr_fire;
      dpe_o     <= any_err || (dpe_o && !clr_dpe_i);
      sse_o     <= serr_fire || (sse_o && !clr_sse_i);
    end
  end
endmodule

// File: rtl/pci_parity_reporter.sv
module pci_parity_reporter
  import ppr_pkg::*;
#(
  parameter int AD_W = 32,
  localparam int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            par_i,
  input  logic            frame_n_i,
  input  logic            irdy_n_i,
  input  logic            trdy_n_i,
  input  logic            claimed_i,
  input  logic            master_i,
  input  logic            perr_en_i,
  input  logic            serr_en_i,
  input  logic            clr_dpe_i,
  input  logic            clr_sse_i,
  output logic            perr_o,
  output logic            perr_oe_o,
  output logic            serr_o,
  output logic            serr_oe_o,
  output logic            dpe_o,
  output logic            sse_o
);
  phase_e          phase_q;
  logic [AD_W-1:0] ad_q;
  logic [BE_W-1:0] cbe_q;
  logic            data_err;
  logic            addr_err;
  logic            spec_err;

  ppr_phase_decode #(.AD_W(AD_W), .BE_W(BE_W)) u_dec (
    .clk(clk), .rst(rst), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
    .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n_i),
    .claimed_i(claimed_i), .master_i(master_i),
    .phase_q(phase_q), .ad_q(ad_q), .cbe_q(cbe_q)
  );

  ppr_parity_check #(.AD_W(AD_W), .BE_W(BE_W)) u_chk_par (
    .phase_q(phase_q), .ad_q(ad_q), .cbe_q(cbe_q), .par_i(par_i),
    .data_err(data_err), .addr_err(addr_err), .spec_err(spec_err)
  );

  ppr_report u_rep (
    .clk(clk), .rst(rst),
    .data_err(data_err), .addr_err(addr_err), .spec_err(spec_err),
    .perr_en_i(perr_en_i), .serr_en_i(serr_en_i),
    .clr_dpe_i(clr_dpe_i), .clr_sse_i(clr_sse_i),
    .perr_o(perr_o), .perr_oe_o(perr_oe_o),
    .serr_o(serr_o), .serr_oe_o(serr_oe_o),
    .dpe_o(dpe_o), .sse_o(sse_o)
  );
endmodule

// File: rtl/ppr_checker.sv
module ppr_checker
  import ppr_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = AD_W / 8
) (
  input logic            clk,
  input logic            rst,
  input phase_e          phase_q,
  input logic [AD_W-1:0] ad_q,
  input logic [BE_W-1:0] cbe_q,
  input logic            par_i,
  input logic            perr_en_i,
  input logic            perr_o,
  input logic            perr_oe_o,
  input logic            serr_o,
  input logic            serr_oe_o,
  input logic            dpe_o,
  input logic            sse_o
);
  // R1
  perr_timing_chk: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_DATA) && ((^{ad_q, cbe_q}) != par_i) && perr_en_i)
      |=> (perr_oe_o && !perr_o));

  // R3
  perr_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(perr_oe_o) && !$past(rst)) |-> $past(perr_o));

  // R3
  perr_low_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !perr_o |-> perr_oe_o);

  // R5
  serr_od_chk: assert property (@(posedge clk) disable iff (rst)
    serr_oe_o |-> !serr_o);

  // R6
  spec_no_perr_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SPEC) |=> !(perr_oe_o && !perr_o));

  // R8
  sse_follow_chk: assert property (@(posedge clk) disable iff (rst)
    serr_oe_o |-> sse_o);

  // R9
  reset_release_chk: assert property (@(posedge clk)
    $past(rst) |-> (!perr_oe_o && !serr_oe_o && !dpe_o && !sse_o));
endmodule

bind pci_parity_reporter ppr_checker #(.AD_W(AD_W), .BE_W(BE_W)) u_ppr_chk (
  .clk(clk), .rst(rst), .phase_q(phase_q), .ad_q(ad_q), .cbe_q(cbe_q),
  .par_i(par_i), .perr_en_i(perr_en_i), .perr_o(perr_o),
  .perr_oe_o(perr_oe_o), .serr_o(serr_o), .serr_oe_o(serr_oe_o),
  .dpe_o(dpe_o), .sse_o(sse_o)
);

// File: tb/pci_parity_reporter_tb.sv
`timescale 1ns/1ps
module pci_parity_reporter_tb;
  localparam int MAXC = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic par = 1'b0, frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic claimed = 1'b0, master = 1'b0, perr_en = 1'b1, serr_en = 1'b1;
  logic clr_dpe = 1'b0, clr_sse = 1'b0;
  logic perr_o, perr_oe_o, serr_o, serr_oe_o, dpe_o, sse_o;

  always #2 clk = ~clk;

  pci_parity_reporter u_dut (
    .clk(clk), .rst(rst), .ad_i(ad), .cbe_n_i(cbe_n), .par_i(par),
    .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
    .claimed_i(claimed), .master_i(master),
    .perr_en_i(perr_en), .serr_en_i(serr_en),
    .clr_dpe_i(clr_dpe), .clr_sse_i(clr_sse),
    .perr_o(perr_o), .perr_oe_o(perr_oe_o), .serr_o(serr_o),
    .serr_oe_o(serr_oe_o), .dpe_o(dpe_o), .sse_o(sse_o)
  );

  // reference model state, indexed by cycle
  bit e_perr [MAXC];
  bit e_serr [MAXC];
  bit e_dpe  [MAXC];
  bit e_sse  [MAXC];
  bit rst_at [MAXC];
  bit clrd_at[MAXC];
  bit clrs_at[MAXC];
  bit m_dpe = 0, m_sse = 0, pend_par = 0, done = 0;
  int cyc = 0, n_chk = 0, n_fail = 0;

  task automatic chk(input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got %0b expected %0b", what, cyc, act, exp);
    end
  endtask

  task automatic compare();
    bit exp_oe;
    if (cyc < 1) return;
    if (rst_at[cyc-1]) begin
      m_dpe = 0; m_sse = 0;
    end else begin
      m_dpe = e_dpe[cyc] | (m_dpe & !clrd_at[cyc-1]);
      m_sse = e_sse[cyc] | (m_sse & !clrs_at[cyc-1]);
    end
    exp_oe = !rst_at[cyc-1] && (e_perr[cyc] || e_perr[cyc-1]);
    chk("R1/R3 perr_oe_o", perr_oe_o, exp_oe);
    if (exp_oe) chk("R2/R3 perr_o level", perr_o, !e_perr[cyc]);
    chk("R5/R6 serr_oe_o", serr_oe_o, !rst_at[cyc-1] && e_serr[cyc]);
    if (serr_oe_o) chk("R5 serr_o drive", serr_o, 1'b0);
    chk("R8/R9 dpe_o", dpe_o, m_dpe);
    chk("R8/R9 sse_o", sse_o, m_sse);
  endtask

  // kind: 0 not checked, 1 address, 2 received data, 3 broadcast data
  task automatic step(input int kind, input bit bad);
    compare();
    par = pend_par;
    pend_par = (^{ad, cbe_n}) ^ bad;
    rst_at[cyc]  = rst;
    clrd_at[cyc] = clr_dpe;
    clrs_at[cyc] = clr_sse;
    if (rst) begin
      e_perr[cyc+1] = 0; e_serr[cyc+1] = 0; e_dpe[cyc+1] = 0; e_sse[cyc+1] = 0;
      e_perr[cyc+2] = 0; e_serr[cyc+2] = 0; e_dpe[cyc+2] = 0; e_sse[cyc+2] = 0;
    end else if (bad && kind != 0) begin
      e_dpe[cyc+2] = 1;
      if (kind == 2 && perr_en) e_perr[cyc+2] = 1;
      if (kind != 2 && serr_en) begin
        e_serr[cyc+2] = 1; e_sse[cyc+2] = 1;
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      frame_n = 1; irdy_n = 1; trdy_n = 1;
      ad = $urandom; cbe_n = 4'($urandom);
      step(0, 0);
    end
  endtask

  task automatic addr(input logic [3:0] cmd, input int kind, input bit bad);
    frame_n = 0; irdy_n = 1; trdy_n = 1;
    ad = $urandom; cbe_n = cmd;
    step(kind, bad);
  endtask

  task automatic data(input bit last, input bit ir, input bit tr,
                      input int kind, input bit bad);
    frame_n = last; irdy_n = ir; trdy_n = tr;
    ad = $urandom; cbe_n = 4'($urandom);
    step(kind, bad);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; idle(4);                    // R9 reset state
    rst = 0; idle(2);
    // R1 single bad phase in a target write
    addr(4'b0111, 0, 0); claimed = 1;
    data(0, 0, 0, 2, 0); data(0, 0, 0, 2, 1); data(0, 0, 0, 2, 0); data(1, 0, 0, 2, 0);
    claimed = 0; idle(4);
    // R2 three consecutive bad phases
    addr(4'b0111, 0, 0); claimed = 1;
    data(0, 0, 0, 2, 1); data(0, 0, 0, 2, 1); data(1, 0, 0, 2, 1);
    claimed = 0; idle(4);
    // R4 wait state with bad parity is ignored
    addr(4'b0111, 0, 0); claimed = 1;
    data(0, 0, 1, 0, 1); data(1, 0, 0, 2, 0);
    claimed = 0; idle(4);
    // R4 unclaimed write and target read are not checked
    addr(4'b0111, 0, 0); data(1, 0, 0, 0, 1); idle(3);
    addr(4'b0110, 0, 0); claimed = 1; data(1, 0, 0, 0, 1); claimed = 0; idle(3);
    // R4 master read checked, master address and master write not
    master = 1;
    addr(4'b0110, 0, 1); data(0, 0, 0, 2, 1); data(1, 0, 0, 2, 0); idle(3);
    addr(4'b0111, 0, 0); data(1, 0, 0, 0, 1); idle(3);
    master = 0;
    // R5 address parity error
    addr(4'b0110, 1, 1); idle(4);
    // R6 broadcast data error goes to system error, then a clean one
    addr(4'b0001, 0, 0); data(1, 0, 1, 3, 1); idle(3);
    addr(4'b0001, 0, 0); data(1, 0, 1, 3, 0); idle(3);
    // R8 clear both flags
    clr_dpe = 1; clr_sse = 1; idle(1); clr_dpe = 0; clr_sse = 0; idle(2);
    // R7 enables off
    perr_en = 0; serr_en = 0;
    addr(4'b0111, 0, 0); claimed = 1; data(1, 0, 0, 2, 1); claimed = 0; idle(3);
    addr(4'b0110, 1, 1); idle(3);
    perr_en = 1; serr_en = 1;
    clr_dpe = 1; idle(1); clr_dpe = 0; idle(2);
    // R8 set wins over clear in the same clock
    addr(4'b0111, 0, 0); claimed = 1; data(1, 0, 0, 2, 1); claimed = 0;
    clr_dpe = 1; idle(1); clr_dpe = 0; idle(3);
    clr_dpe = 1; clr_sse = 1; idle(1); clr_dpe = 0; clr_sse = 0; idle(2);
    // R1/R5 bad last data directly followed by bad address phase
    addr(4'b0111, 0, 0); claimed = 1; data(1, 0, 0, 2, 1); claimed = 0;
    addr(4'b0110, 1, 1); idle(4);
    // R9 reset discards an in-flight error
    addr(4'b0111, 0, 0); claimed = 1; data(1, 0, 0, 2, 1); claimed = 0;
    rst = 1; idle(1); rst = 0; idle(4);
    compare();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule